// File: doc/BRIEF.md
# Thermal-Aware CPU Performance-State Cap Controller

This block sits beside a CPU boost controller and decides the fastest performance state that controller is allowed to grant. While the die is comfortably cool the cap stays at the fastest state, so boosting is unrestricted. When the peak die temperature comes close to the thermal limit, the block searches for the critical cap. This is the slowest CPU state at which a combined performance measure does not drop. The measure is the sum of a GPU memory-bandwidth sample and a CPU IPC sample. The aim is that the CPU's heat does not eat the GPU's thermal headroom when the CPU gains nothing from the extra speed.

The search moves only on periodic ticks and works by halving the remaining interval. It first measures a baseline at the fastest capped state. Each trial cap is then held for a programmable number of ticks before the samples are compared with the best result seen so far. A trial that loses performance is rejected and the cap moves back toward faster states. When the interval closes, the best cap is held until the die cools below a hysteresis band. If the temperature goes above the limit itself, the cap is forced to the slowest state at once.

States: IDLE (cap at the fastest state), BASE (baseline measurement at the first capped state), TRIAL (a candidate cap under measurement), HOLD (search converged, best cap applied) and HOT (over the limit, slowest state forced). Transitions:
- IDLE→BASE on a tick when the die is near the limit.
- BASE→TRIAL when the dwell expires.
- TRIAL→TRIAL on a dwell expiry that leaves the interval open.
- TRIAL→HOLD on a dwell expiry that closes the interval.
- BASE/TRIAL/HOLD/HOT→IDLE on a tick when the die is cool.
- Any state→HOT whenever the temperature exceeds the limit.
- HOT→BASE on a tick once the temperature is no longer over the limit and is not cool.

Top module: `pstate_cap_ctrl`

## Requirements
- R1: After reset, `cap_o` is 0, the fastest state, which means no cap.
- R2: While `cap_o` is 0, it stays 0 until a tick arrives with `temp_i + margin_i >= limit_i`. Cycles without a tick, and ticks with a cooler die, leave it at 0.
- R3: A tick with `temp_i + margin_i >= limit_i` while uncapped sets `cap_o` to 1 at the following clock edge. This is the baseline measurement.
- R4: `cap_o` changes only on a cycle with `tick_i` high, apart from the over-limit case of R8. Each baseline or trial cap is sampled on its `dwell_i`-th tick. A `dwell_i` of 0 acts as 1.
- R5: The performance measure is `gpu_bw_i + cpu_ipc_i`. A trial is accepted when its measure is greater than or equal to the best measure recorded so far. The baseline measure is recorded as the first best.
- R6: The search interval starts as [1, 6], with 1 as the baseline best. Each trial cap is the rounded-up midpoint (lo+hi+1)/2, so the first trial is 4. An accepted trial sets lo to the trial value. A rejected trial sets hi to the trial value minus 1.
- R7: A rejected trial moves the cap back to a faster state. When lo equals hi, the search ends and `cap_o` holds the best accepted cap, or 1 if no trial was accepted. It stays there through later ticks while the die remains near the limit.
- R8: When `temp_i > limit_i`, `cap_o` becomes 6 at the next clock edge with no tick needed, and stays 6 while over the limit. The first tick after that which finds the die neither over nor cool restarts the search at cap 1.
- R9: On a tick with `temp_i + margin_i + hyst_i < limit_i`, and not over the limit, `cap_o` returns to 0. A tick with the temperature inside the hysteresis band keeps the current cap.
- R10: Cap encoding: 0 is the unrestricted boost state, 1 the lower boost state, and 2 to 6 the visible states from fastest to slowest. The value 7 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic control tick, one cycle wide |
| temp_i | input | TEMP_W | Peak die temperature |
| limit_i | input | TEMP_W | Thermal limit |
| margin_i | input | TEMP_W | Near-limit margin below the limit |
| hyst_i | input | TEMP_W | Exit hysteresis band below the near threshold |
| dwell_i | input | DWELL_W | Ticks each trial cap is held before sampling |
| gpu_bw_i | input | BW_W | GPU memory-bandwidth sample |
| cpu_ipc_i | input | IPC_W | CPU IPC sample |
| cap_o | output | 3 | Current cap index (slowest-allowed fastest state) |

## Verification
Every result comes from a single register stage. A tick driven in one cycle, or a temperature that crosses the limit, shows on `cap_o` after the next rising edge and no later. The bench drives inputs on falling edges and raises the tick for one full cycle. It then reads `cap_o` at the following falling edge, half a period after the edge that updates it. Dwell sequences are counted tick by tick, so every intermediate tick is checked to show that the cap has not moved early. Stretches without a tick are checked to show that the cap stays put.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BASE  = 3'd1,
        ST_TRIAL = 3'd2,
        ST_HOLD  = 3'd3,
        ST_HOT   = 3'd4
    } cap_state_e;

    localparam int CAP_W = 3;

    // Cap index encoding: 0 = unrestricted boost, 1 = lower boost,
    // 2..6 = visible states from fastest to slowest.
    localparam logic [CAP_W-1:0] CAP_NONE  = 3'd0;
    localparam logic [CAP_W-1:0] CAP_FIRST = 3'd1;
    localparam logic [CAP_W-1:0] CAP_LAST  = 3'd6;

endpackage

// File: rtl/pcap_therm_win.sv
// Temperature window decode: near, cool (below hysteresis) and over-limit.
module pcap_therm_win #(
    parameter int TEMP_W = 8
) (
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] limit_i,
    input  logic [TEMP_W-1:0] margin_i,
    input  logic [TEMP_W-1:0] hyst_i,
    output logic              near_o,
    output logic              cool_o,
    output logic              over_o
);
    localparam int WW = TEMP_W + 2;

    logic [WW-1:0] t_w, l_w, m_w, h_w;

    always_comb begin
        t_w    = WW'(temp_i);
        l_w    = WW'(limit_i);
        m_w    = WW'(margin_i);
        h_w    = WW'(hyst_i);
        near_o = (t_w + m_w) >= l_w;
        cool_o = (t_w + m_w + h_w) < l_w;
        over_o = t_w > l_w;
    end

endmodule

// File: rtl/pcap_dwell.sv
// Counts ticks spent at the current cap; flags the tick that completes the dwell.
module pcap_dwell #(
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic               due_o
);
    logic [DWELL_W-1:0] cnt_q;
    logic [DWELL_W:0]   need;
    logic [DWELL_W:0]   seen;

    always_comb begin
        need  = (dwell_i == '0) ? (DWELL_W+1)'(1) : {1'b0, dwell_i};
        seen  = {1'b0, cnt_q} + (DWELL_W+1)'(1);
        due_o = tick_i && (seen >= need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pcap_bisect.sv
// One narrowing step of the cap search: judge the trial and shrink the interval.
module pcap_bisect #(
    parameter int PERF_W = 13
) (
    input  logic [2:0]        lo_i,
    input  logic [2:0]        hi_i,
    input  logic [2:0]        trial_i,
    input  logic [PERF_W-1:0] perf_i,
    input  logic [PERF_W-1:0] best_perf_i,
    output logic              pass_o,
    output logic [2:0]        lo_o,
    output logic [2:0]        hi_o,
    output logic [2:0]        next_o,
    output logic              done_o
);
    logic [3:0] sum;

    always_comb begin
        pass_o = perf_i >= best_perf_i;
        lo_o   = pass_o ? trial_i : lo_i;
        hi_o   = pass_o ? hi_i : (trial_i - 3'd1);
        done_o = lo_o >= hi_o;
        sum    = {1'b0, lo_o} + {1'b0, hi_o} + 4'd1;
        next_o = sum[3:1];
    end

endmodule

// File: rtl/pstate_cap_ctrl.sv
module pstate_cap_ctrl #(
    parameter int TEMP_W  = 8,
    parameter int BW_W    = 12,
    parameter int IPC_W   = 8,
    parameter int DWELL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [TEMP_W-1:0]  temp_i,
    input  logic [TEMP_W-1:0]  limit_i,
    input  logic [TEMP_W-1:0]  margin_i,
    input  logic [TEMP_W-1:0]  hyst_i,
    input  logic [DWELL_W-1:0] dwell_i,
    input  logic [BW_W-1:0]    gpu_bw_i,
    input  logic [IPC_W-1:0]   cpu_ipc_i,
    output logic [2:0]         cap_o
);
    import pcap_pkg::*;

    localparam int PERF_W = ((BW_W > IPC_W) ? BW_W : IPC_W) + 1;

    cap_state_e        state_q, state_d;
    logic [2:0]        lo_q, lo_d, hi_q, hi_d;
    logic [2:0]        trial_q, trial_d, best_q, best_d;
    logic [PERF_W-1:0] best_perf_q, best_perf_d;
    logic [PERF_W-1:0] perf;
    logic [2:0]        cap_d;
    logic              near, cool, over, due, clr;
    logic              b_pass, b_done;
    logic [2:0]        b_lo, b_hi, b_next;

    assign perf = PERF_W'(gpu_bw_i) + PERF_W'(cpu_ipc_i);

    pcap_therm_win #(.TEMP_W(TEMP_W)) u_win (
        .temp_i   (temp_i),
        .limit_i  (limit_i),
        .margin_i (margin_i),
        .hyst_i   (hyst_i),
        .near_o   (near),
        .cool_o   (cool),
        .over_o   (over)
    );

    pcap_dwell #(.DWELL_W(DWELL_W)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr),
        .tick_i  (tick_i),
        .dwell_i (dwell_i),
        .due_o   (due)
    );

    pcap_bisect #(.PERF_W(PERF_W)) u_bisect (
        .lo_i        (lo_q),
        .hi_i        (hi_q),
        .trial_i     (trial_q),
        .perf_i      (perf),
        .best_perf_i (best_perf_q),
        .pass_o      (b_pass),
        .lo_o        (b_lo),
        .hi_o        (b_hi),
        .next_o      (b_next),
        .done_o      (b_done)
    );

    // Next-state and search datapath
    always_comb begin
        state_d     = state_q;
        lo_d        = lo_q;
        hi_d        = hi_q;
        trial_d     = trial_q;
        best_d      = best_q;
        best_perf_d = best_perf_q;
        clr         = 1'b0;
        if (over) begin
            state_d = ST_HOT;
            clr     = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tick_i && near) begin
                        state_d = ST_BASE;
                        clr     = 1'b1;
                    end
                end
                ST_BASE: begin
                    if (tick_i && cool) begin
                        state_d = ST_IDLE;
                        clr     = 1'b1;
                    end else if (due) begin
                        state_d     = ST_TRIAL;
                        lo_d        = CAP_FIRST;
                        hi_d        = CAP_LAST;
                        best_d      = CAP_FIRST;
                        best_perf_d = perf;
                        trial_d     = 3'((4'(CAP_FIRST) + 4'(CAP_LAST) + 4'd1) >> 1);
                        clr         = 1'b1;
                    end
                end
                ST_TRIAL: begin
                    if (tick_i && cool) begin
                        state_d = ST_IDLE;
                        clr     = 1'b1;
                    end else if (due) begin
                        lo_d = b_lo;
                        hi_d = b_hi;
                        clr  = 1'b1;
                        if (b_pass) begin
                            best_d      = trial_q;
                            best_perf_d = perf;
                        end
                        if (b_done) begin
                            state_d = ST_HOLD;
                        end else begin
                            trial_d = b_next;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick_i && cool) begin
                        state_d = ST_IDLE;
                        clr     = 1'b1;
                    end
                end
                ST_HOT: begin
                    if (tick_i && cool) begin
                        state_d = ST_IDLE;
                        clr     = 1'b1;
                    end else if (tick_i) begin
                        state_d = ST_BASE;
                        clr     = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    clr     = 1'b1;
                end
            endcase
        end
    end

    // Output decode from the next state
    always_comb begin
        unique case (state_d)
            ST_IDLE:  cap_d = CAP_NONE;
            ST_BASE:  cap_d = CAP_FIRST;
            ST_TRIAL: cap_d = trial_d;
            ST_HOLD:  cap_d = best_d;
            ST_HOT:   cap_d = CAP_LAST;
            default:  cap_d = CAP_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lo_q        <= CAP_FIRST;
            hi_q        <= CAP_LAST;
            trial_q     <= CAP_FIRST;
            best_q      <= CAP_FIRST;
            best_perf_q <= '0;
            cap_o       <= CAP_NONE;
        end else begin
            state_q     <= state_d;
            lo_q        <= lo_d;
            hi_q        <= hi_d;
            trial_q     <= trial_d;
            best_q      <= best_d;
            best_perf_q <= best_perf_d;
            cap_o       <= cap_d;
        end
    end

endmodule

// File: rtl/pstate_cap_ctrl_chk.sv
module pstate_cap_ctrl_chk #(
    parameter int TEMP_W  = 8,
    parameter int BW_W    = 12,
    parameter int IPC_W   = 8,
    parameter int DWELL_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic [TEMP_W-1:0]  temp_i,
    input logic [TEMP_W-1:0]  limit_i,
    input logic [TEMP_W-1:0]  margin_i,
    input logic [TEMP_W-1:0]  hyst_i,
    input logic [DWELL_W-1:0] dwell_i,
    input logic [BW_W-1:0]    gpu_bw_i,
    input logic [IPC_W-1:0]   cpu_ipc_i,
    input logic [2:0]         cap_o
);
    localparam int WW = TEMP_W + 2;

    logic hot_in, near_in, cool_in;
    assign hot_in  = WW'(temp_i) > WW'(limit_i);
    assign near_in = (WW'(temp_i) + WW'(margin_i)) >= WW'(limit_i);
    assign cool_in = (WW'(temp_i) + WW'(margin_i) + WW'(hyst_i)) < WW'(limit_i);

    // R10
    cap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o <= 3'd6);

    // R8
    hot_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot_in |=> (cap_o == 3'd6));

    // R4
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !hot_in) |=> $stable(cap_o));

    // R9
    cool_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cool_in && !hot_in) |=> (cap_o == 3'd0));

    // R2
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_o == 3'd0) && !hot_in && !(tick_i && near_in)) |=> (cap_o == 3'd0));

    // R3
    entry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_o == 3'd0) && tick_i && near_in && !hot_in) |=> (cap_o == 3'd1));

endmodule

bind pstate_cap_ctrl pstate_cap_ctrl_chk #(
    .TEMP_W (TEMP_W),
    .BW_W   (BW_W),
    .IPC_W  (IPC_W),
    .DWELL_W(DWELL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .temp_i    (temp_i),
    .limit_i   (limit_i),
    .margin_i  (margin_i),
    .hyst_i    (hyst_i),
    .dwell_i   (dwell_i),
    .gpu_bw_i  (gpu_bw_i),
    .cpu_ipc_i (cpu_ipc_i),
    .cap_o     (cap_o)
);

// File: tb/pstate_cap_ctrl_tb.sv
`timescale 1ns/1ps
module pstate_cap_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [7:0]  temp_i = 8'd80;
    logic [7:0]  limit_i = 8'd100;
    logic [7:0]  margin_i = 8'd5;
    logic [7:0]  hyst_i = 8'd4;
    logic [3:0]  dwell_i = 4'd2;
    logic [11:0] gpu_bw_i = 12'd100;
    logic [7:0]  cpu_ipc_i = 8'd50;
    logic [2:0]  cap_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pstate_cap_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .temp_i    (temp_i),
        .limit_i   (limit_i),
        .margin_i  (margin_i),
        .hyst_i    (hyst_i),
        .dwell_i   (dwell_i),
        .gpu_bw_i  (gpu_bw_i),
        .cpu_ipc_i (cpu_ipc_i),
        .cap_o     (cap_o)
    );

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if (cap_o !== exp) begin
            n_bad++;
            $display("FAIL %s: cap_o actual %0d expected %0d", req, cap_o, exp);
        end
    endtask

    // One-cycle tick, result read at the falling edge after the update edge.
    task automatic pulse_chk(input string req, input logic [2:0] exp);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check(req, exp);
    endtask

    task automatic t_reset_idle();
        @(negedge clk);
        check("R1", 3'd0);
        temp_i = 8'd94;
        pulse_chk("R2", 3'd0);
        repeat (3) @(negedge clk);
        check("R2", 3'd0);
    endtask

    task automatic t_all_accept();
        dwell_i = 4'd2; gpu_bw_i = 12'd100; cpu_ipc_i = 8'd50;
        temp_i = 8'd97;
        pulse_chk("R3", 3'd1);
        pulse_chk("R4", 3'd1);
        pulse_chk("R6", 3'd4);
        repeat (5) @(negedge clk);
        check("R4", 3'd4);
        pulse_chk("R4", 3'd4);
        pulse_chk("R5", 3'd5);
        pulse_chk("R4", 3'd5);
        pulse_chk("R6", 3'd6);
        pulse_chk("R4", 3'd6);
        pulse_chk("R7", 3'd6);
        pulse_chk("R7", 3'd6);
        temp_i = 8'd93;
        pulse_chk("R9", 3'd6);
        temp_i = 8'd90;
        pulse_chk("R9", 3'd0);
    endtask

    task automatic t_reject();
        dwell_i = 4'd2; gpu_bw_i = 12'd100; cpu_ipc_i = 8'd50;
        temp_i = 8'd97;
        pulse_chk("R3", 3'd1);
        pulse_chk("R4", 3'd1);
        pulse_chk("R6", 3'd4);
        gpu_bw_i = 12'd60;
        pulse_chk("R4", 3'd4);
        pulse_chk("R7", 3'd2);
        gpu_bw_i = 12'd100;
        pulse_chk("R4", 3'd2);
        pulse_chk("R6", 3'd3);
        gpu_bw_i = 12'd60;
        pulse_chk("R4", 3'd3);
        pulse_chk("R7", 3'd2);
        pulse_chk("R7", 3'd2);
        temp_i = 8'd80;
        pulse_chk("R9", 3'd0);
    endtask

    task automatic t_over();
        dwell_i = 4'd2; gpu_bw_i = 12'd100;
        temp_i = 8'd97;
        pulse_chk("R3", 3'd1);
        @(negedge clk);
        temp_i = 8'd101;
        @(negedge clk);
        check("R8", 3'd6);
        pulse_chk("R8", 3'd6);
        temp_i = 8'd100;
        repeat (2) @(negedge clk);
        check("R8", 3'd6);
        temp_i = 8'd97;
        pulse_chk("R8", 3'd1);
        temp_i = 8'd80;
        pulse_chk("R9", 3'd0);
    endtask

    task automatic t_zero_dwell_tie();
        dwell_i = 4'd0; gpu_bw_i = 12'd100; cpu_ipc_i = 8'd50;
        temp_i = 8'd95;
        pulse_chk("R3", 3'd1);
        pulse_chk("R4", 3'd4);
        gpu_bw_i = 12'd90; cpu_ipc_i = 8'd60;
        pulse_chk("R5", 3'd5);
        gpu_bw_i = 12'd90; cpu_ipc_i = 8'd59;
        pulse_chk("R5", 3'd4);
        temp_i = 8'd80;
        pulse_chk("R9", 3'd0);
        check("R10", 3'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_all_accept();
        t_reject();
        t_over();
        t_zero_dwell_tie();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule